// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

Internal sources hand this block one interrupt event at a time. Each event is packed into a 16-byte vector of four 32-bit words and written word by word into a circular buffer in memory. The buffer's size is a power of two and its start is aligned to 256 bytes. The block owns the write pointer. The host consumes vectors and returns its progress as a read pointer, written either through the register interface or through a doorbell write that carries a matching index. While the two pointers differ, the block raises an interrupt line. This is a steady level by default. In re-arm mode it is a one-cycle pulse for each new vector and for each host read-pointer update that leaves work pending.

Both pointers count bytes. The ring size is programmed as log2 of its length in 32-bit words. A vector that would land on unread data is dropped and counted, and a sticky overflow flag is set inside the write-pointer register. Optionally, every write-pointer change, and every overflow, is copied to a programmed memory word so the host can poll memory instead of registers.

Register map (word offsets on `reg_addr`): 0 control, 1 ring base (address bits 39:8), 2 writeback address bits 31:2 (in data bits 31:2), 3 writeback address bits 39:32 (in data bits 7:0), 4 read pointer, 5 write pointer (read-only, overflow in bit 31), 6 doorbell setup (bit 16 enable, bits 9:0 index), 7 lost-event count (read-only). Control bits: 0 ring enable, 1 interrupt enable, 2 overflow clear, 3 writeback enable, 4 re-arm mode, 12:8 log2 of ring words.

Top module: `ivr_producer`

## Requirements
- R1: After reset both pointers, the overflow flag and the lost count are 0, `irq`, `busy` and `mem_we` are low, and `ev_ready` is high.
- R2: An accepted event produces four memory writes on consecutive cycles at byte addresses {base,8'h00} + wptr + 0, 4, 8 and 12. Word 0 is {24'b0, src}, word 1 is {4'b0, data[27:0]}, word 2 is {pasid, vm, ring} (pasid in bits 31:16, vm in 15:8, ring in 7:0), and word 3 is 0.
- R3: After each stored vector the write pointer becomes (wptr + 16) AND mask, where mask = (4 << log2words) - 1. The write pointer is always a multiple of 16.
- R4: An event that arrives when (wptr + 16) AND mask equals the read pointer is dropped. It causes no vector write, leaves the write pointer unchanged, sets bit 31 of the write-pointer register and adds 1 to the lost count.
- R5: While control bit 2 is 1, the overflow flag reads 0 and stays 0 even if events are dropped. Once the bit is written back to 0, the next drop sets the flag again.
- R6: With control bit 3 set, each write-pointer update and each drop is followed by one extra memory write. Its data is {overflow, 31-bit write pointer} and its address is {hi[7:0], lo[31:2], 2'b00}.
- R7: Events are stored only when control bits 0 and 1 are both 1. Otherwise they are consumed with no memory write. While bit 0 is 0, both pointers and the overflow flag are held at 0.
- R8: When doorbell mode is enabled (setup bit 16), a doorbell write whose index equals setup bits 9:0 loads the read pointer. Doorbells with another index are ignored, and so are register writes to the read pointer. When doorbell mode is off, only the register write loads it. A loaded value has its low 4 bits cleared and is masked to the ring size.
- R9: In level mode (control bit 4 = 0), `irq` is high one cycle after the pointers differ with both enables set. It is low one cycle after they are equal or either enable is 0.
- R10: In re-arm mode, `irq` is a one-cycle pulse. It fires one cycle after a vector is stored, or one cycle after a host read-pointer load, provided the ring is then non-empty. It stays low otherwise.
- R11: While a vector is being written, `busy` is high and `ev_ready` is low. After acceptance this lasts three cycles, plus one cycle when writeback is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken this cycle when high with ev_valid |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | Process address-space id |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe, data valid next cycle |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| db_we | input | 1 | Doorbell write strobe |
| db_index | input | DB_IDX_W | Doorbell index |
| db_data | input | PTR_W | Doorbell read-pointer value |
| mem_we | output | 1 | Memory word write |
| mem_addr | output | 40 | Byte address of the word |
| mem_wdata | output | 32 | Word data |
| busy | output | 1 | Vector write in progress |
| irq | output | 1 | Interrupt to host |

## Verification
Some properties are checked on every cycle. The write pointer stays 16-byte aligned. It holds still on a drop. Both pointers sit at zero while the ring is off. The overflow flag stays clear while the clear bit is held. A register write to the read pointer has no effect in doorbell mode. The interrupt is silent whenever an enable is off. Other behaviour only the directed scenarios can show: the exact packing and addresses of the words, wrap at the ring end, the lost count, the writeback word, the single-cycle re-arm pulses, and the busy window.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ADDR_W = 40;
  localparam int VEC_BYTES = 16;

  localparam logic [2:0] RG_CTRL  = 3'd0;
  localparam logic [2:0] RG_BASE  = 3'd1;
  localparam logic [2:0] RG_WBLO  = 3'd2;
  localparam logic [2:0] RG_WBHI  = 3'd3;
  localparam logic [2:0] RG_RPTR  = 3'd4;
  localparam logic [2:0] RG_WPTR  = 3'd5;
  localparam logic [2:0] RG_DBELL = 3'd6;
  localparam logic [2:0] RG_LOST  = 3'd7;

  typedef struct packed {
    logic [4:0] log2w;
    logic       rearm;
    logic       wb_en;
    logic       ovf_clr;
    logic       intr_en;
    logic       ring_en;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_W1, ST_W2, ST_W3, ST_WB
  } wr_state_t;
endpackage

// File: rtl/ivr_cfg.sv
module ivr_cfg
  import ivr_pkg::*;
#(
  parameter int PTR_W    = 18,
  parameter int LOST_W   = 16,
  parameter int DB_IDX_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                db_we,
  input  logic [DB_IDX_W-1:0] db_index,
  input  logic [PTR_W-1:0]    db_data,
  input  logic [PTR_W-1:0]    wptr,
  input  logic                ovf,
  input  logic [LOST_W-1:0]   lost,
  output ctrl_t               ctrl,
  output logic [31:0]         base,
  output logic [ADDR_W-1:0]   wb_addr,
  output logic [PTR_W-1:0]    ptr_mask,
  output logic [PTR_W-1:0]    rptr,
  output logic                rptr_wr
);
  logic [29:0]         wb_lo;
  logic [7:0]          wb_hi;
  logic                db_en;
  logic [DB_IDX_W-1:0] db_idx;
  logic                db_hit;
  logic                reg_rptr_wr;
  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(VEC_BYTES - 1);

  // Mask of byte-pointer bits inside the ring: (4 << log2w) - 1
  always_comb begin
    for (int i = 0; i < PTR_W; i++)
      ptr_mask[i] = (i < int'(ctrl.log2w) + 2);
  end

  assign wb_addr     = {wb_hi, wb_lo, 2'b00};
  assign db_hit      = db_en && db_we && (db_index == db_idx);
  assign reg_rptr_wr = !db_en && reg_we && (reg_addr == RG_RPTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      base   <= '0;
      wb_lo  <= '0;
      wb_hi  <= '0;
      db_en  <= 1'b0;
      db_idx <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RG_CTRL:  ctrl   <= {reg_wdata[12:8], reg_wdata[4:0]};
        RG_BASE:  base   <= reg_wdata;
        RG_WBLO:  wb_lo  <= reg_wdata[31:2];
        RG_WBHI:  wb_hi  <= reg_wdata[7:0];
        RG_DBELL: begin
          db_en  <= reg_wdata[16];
          db_idx <= reg_wdata[DB_IDX_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Host read pointer: doorbell path or register path, never both
  always_ff @(posedge clk) begin
    if (rst) begin
      rptr    <= '0;
      rptr_wr <= 1'b0;
    end else begin
      rptr_wr <= 1'b0;
      if (!ctrl.ring_en) begin
        rptr <= '0;
      end else if (db_hit) begin
        rptr    <= db_data & ptr_mask & ALIGN;
        rptr_wr <= 1'b1;
      end else if (reg_rptr_wr) begin
        rptr    <= reg_wdata[PTR_W-1:0] & ptr_mask & ALIGN;
        rptr_wr <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        RG_CTRL:  reg_rdata <= {19'b0, ctrl.log2w, 3'b0, ctrl.rearm, ctrl.wb_en,
                                ctrl.ovf_clr, ctrl.intr_en, ctrl.ring_en};
        RG_BASE:  reg_rdata <= base;
        RG_WBLO:  reg_rdata <= {wb_lo, 2'b00};
        RG_WBHI:  reg_rdata <= {24'b0, wb_hi};
        RG_RPTR:  reg_rdata <= 32'(rptr);
        RG_WPTR:  reg_rdata <= {ovf, 31'(wptr)};
        RG_DBELL: reg_rdata <= 32'(db_idx) | (32'(db_en) << 16);
        default:  reg_rdata <= 32'(lost);
      endcase
    end
  end

  a_r7_rptr_zero_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ring_en |=> (rptr == '0));

  a_r8_reg_rptr_ignored: assert property (@(posedge clk) disable iff (rst)
    (db_en && ctrl.ring_en && reg_we && reg_addr == RG_RPTR && !db_hit) |=> $stable(rptr));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 18,
  parameter int LOST_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_en,
  input  logic              active,
  input  logic              ovf_clr,
  input  logic              wb_en,
  input  logic [PTR_W-1:0]  ptr_mask,
  input  logic [PTR_W-1:0]  rptr,
  input  logic [31:0]       base,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_src,
  input  logic [27:0]       ev_data,
  input  logic [7:0]        ev_ring,
  input  logic [7:0]        ev_vm,
  input  logic [15:0]       ev_pasid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              busy,
  output logic [PTR_W-1:0]  wptr,
  output logic              ovf,
  output logic [LOST_W-1:0] lost,
  output logic              commit
);
  wr_state_t         state;
  logic [31:0]       hold1, hold2;
  logic [PTR_W-1:0]  nxt;
  logic              full, accept, store, drop;
  logic [ADDR_W-1:0] slot;

  assign ev_ready = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign accept   = ev_valid && ev_ready;
  assign nxt      = (wptr + PTR_W'(VEC_BYTES)) & ptr_mask;
  assign full     = (nxt == rptr);
  assign store    = accept && active && !full;
  assign drop     = accept && active && full;
  assign slot     = {base, 8'h00} + ADDR_W'(wptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wptr      <= '0;
      ovf       <= 1'b0;
      lost      <= '0;
      commit    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      hold1     <= '0;
      hold2     <= '0;
    end else begin
      commit <= 1'b0;
      mem_we <= 1'b0;
      if (!ring_en) begin
        state <= ST_IDLE;
        wptr  <= '0;
        ovf   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (store) begin
              mem_we    <= 1'b1;
              mem_addr  <= slot;
              mem_wdata <= {24'b0, ev_src};
              hold1     <= {4'b0, ev_data};
              hold2     <= {ev_pasid, ev_vm, ev_ring};
              state     <= ST_W1;
            end else if (drop) begin
              ovf  <= 1'b1;
              lost <= lost + 1'b1;
              if (wb_en) state <= ST_WB;
            end
          end
          ST_W1: begin
            mem_we    <= 1'b1;
            mem_addr  <= slot + ADDR_W'(4);
            mem_wdata <= hold1;
            state     <= ST_W2;
          end
          ST_W2: begin
            mem_we    <= 1'b1;
            mem_addr  <= slot + ADDR_W'(8);
            mem_wdata <= hold2;
            state     <= ST_W3;
          end
          ST_W3: begin
            mem_we    <= 1'b1;
            mem_addr  <= slot + ADDR_W'(12);
            mem_wdata <= '0;
            wptr      <= nxt;
            commit    <= 1'b1;
            state     <= wb_en ? ST_WB : ST_IDLE;
          end
          ST_WB: begin
            mem_we    <= 1'b1;
            mem_addr  <= wb_addr;
            mem_wdata <= {ovf, 31'(wptr)};
            state     <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
        if (ovf_clr) ovf <= 1'b0;
      end
    end
  end

  a_r3_wptr_aligned: assert property (@(posedge clk) disable iff (rst)
    wptr[3:0] == 4'd0);

  a_r4_drop_holds_wptr: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(wptr));

  a_r5_clear_holds: assert property (@(posedge clk) disable iff (rst)
    (ring_en && ovf_clr) |=> !ovf);

  a_r7_wptr_zero_off: assert property (@(posedge clk) disable iff (rst)
    !ring_en |=> (wptr == '0 && !ovf));

  a_r2_first_word_out: assert property (@(posedge clk) disable iff (rst)
    (state == ST_W1) |-> mem_we);
endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
  import ivr_pkg::*;
#(
  parameter int PTR_W    = 18,
  parameter int LOST_W   = 16,
  parameter int DB_IDX_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_valid,
  output logic                ev_ready,
  input  logic [7:0]          ev_src,
  input  logic [27:0]         ev_data,
  input  logic [7:0]          ev_ring,
  input  logic [7:0]          ev_vm,
  input  logic [15:0]         ev_pasid,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                db_we,
  input  logic [DB_IDX_W-1:0] db_index,
  input  logic [PTR_W-1:0]    db_data,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  output logic                busy,
  output logic                irq
);
  ctrl_t               ctrl;
  logic [31:0]         base;
  logic [ADDR_W-1:0]   wb_addr;
  logic [PTR_W-1:0]    ptr_mask, rptr, wptr;
  logic                rptr_wr, ovf, commit, active, pend;
  logic [LOST_W-1:0]   lost;

  assign active = ctrl.ring_en && ctrl.intr_en;
  assign pend   = (rptr != wptr);

  ivr_cfg #(.PTR_W(PTR_W), .LOST_W(LOST_W), .DB_IDX_W(DB_IDX_W)) u_cfg (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .db_we(db_we), .db_index(db_index), .db_data(db_data),
    .wptr(wptr), .ovf(ovf), .lost(lost),
    .ctrl(ctrl), .base(base), .wb_addr(wb_addr), .ptr_mask(ptr_mask),
    .rptr(rptr), .rptr_wr(rptr_wr)
  );

  ivr_writer #(.PTR_W(PTR_W), .LOST_W(LOST_W)) u_wr (
    .clk(clk), .rst(rst),
    .ring_en(ctrl.ring_en), .active(active), .ovf_clr(ctrl.ovf_clr),
    .wb_en(ctrl.wb_en), .ptr_mask(ptr_mask), .rptr(rptr),
    .base(base), .wb_addr(wb_addr),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring),
    .ev_vm(ev_vm), .ev_pasid(ev_pasid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wptr(wptr), .ovf(ovf), .lost(lost), .commit(commit)
  );

  // Level while work is pending, or single pulses in re-arm mode
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (ctrl.rearm) irq <= active && pend && (commit || rptr_wr);
    else irq <= active && pend;
  end

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !active |=> !irq);
endmodule

// File: tb/ivr_producer_test.sv
`timescale 1ns/1ps
module ivr_producer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [7:0]  ev_src = '0;
  logic [27:0] ev_data = '0;
  logic [7:0]  ev_ring = '0;
  logic [7:0]  ev_vm = '0;
  logic [15:0] ev_pasid = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        db_we = 1'b0;
  logic [9:0]  db_index = '0;
  logic [17:0] db_data = '0;
  logic        mem_we;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        busy, irq;

  int total = 0, bad = 0;
  logic [39:0] log_a[$];
  logic [31:0] log_d[$];
  localparam logic [39:0] BASE_A = 40'h12_3456_7800;

  ivr_producer uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vm(ev_vm),
    .ev_pasid(ev_pasid), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .db_we(db_we), .db_index(db_index), .db_data(db_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (mem_we) begin
    log_a.push_back(mem_addr);
    log_d.push_back(mem_wdata);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] dt, input logic [7:0] rg,
                      input logic [7:0] vm, input logic [15:0] pa);
    @(negedge clk);
    ev_valid = 1'b1; ev_src = s; ev_data = dt; ev_ring = rg; ev_vm = vm; ev_pasid = pa;
    while (!ev_ready) @(negedge clk);
    @(posedge clk); @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic bell(input logic [9:0] idx, input logic [17:0] v);
    @(negedge clk); db_we = 1'b1; db_index = idx; db_data = v;
    @(posedge clk); @(negedge clk); db_we = 1'b0;
  endtask

  task automatic clear_log();
    log_a.delete(); log_d.delete();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(irq == 1'b0 && busy == 1'b0 && mem_we == 1'b0, "R1 outputs idle", {irq, busy, mem_we}, 0);
    chk(ev_ready == 1'b1, "R1 ready", ev_ready, 1);
    rd(3'd5, v); chk(v == 0, "R1 wptr", v, 0);
    rd(3'd7, v); chk(v == 0, "R1 lost", v, 0);
  endtask

  task automatic t_pack();
    logic [31:0] v;
    wr(3'd1, 32'h1234_5678);
    wr(3'd0, 32'h0000_0403);
    clear_log();
    send(8'hA5, 28'hFABCDEF, 8'h11, 8'h22, 16'hBEEF);
    chk(busy == 1'b1 && ev_ready == 1'b0, "R11 busy window start", {busy, ev_ready}, 2'b10);
    cyc(2);
    chk(busy == 1'b1, "R11 busy third cycle", busy, 1);
    cyc(1);
    chk(busy == 1'b0 && ev_ready == 1'b1, "R11 busy window end", {busy, ev_ready}, 2'b01);
    cyc(4);
    chk(log_a.size() == 4, "R2 word count", log_a.size(), 4);
    if (log_a.size() == 4) begin
      chk(log_a[0] == BASE_A && log_d[0] == 32'h0000_00A5, "R2 word0", {log_a[0], log_d[0]}, {BASE_A, 32'hA5});
      chk(log_a[1] == BASE_A + 4 && log_d[1] == 32'h0FAB_CDEF, "R2 word1", {log_a[1], log_d[1]}, {BASE_A + 40'd4, 32'h0FABCDEF});
      chk(log_a[2] == BASE_A + 8 && log_d[2] == 32'hBEEF_2211, "R2 word2", {log_a[2], log_d[2]}, {BASE_A + 40'd8, 32'hBEEF2211});
      chk(log_a[3] == BASE_A + 12 && log_d[3] == 32'h0, "R2 word3", {log_a[3], log_d[3]}, {BASE_A + 40'd12, 32'h0});
    end
    rd(3'd5, v); chk(v == 32'd16, "R3 wptr step", v, 16);
    chk(irq == 1'b1, "R9 level high when pending", irq, 1);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(3'd4, 32'd16);
    cyc(2);
    chk(irq == 1'b0, "R9 level low when equal", irq, 0);
    send(8'h01, 28'h1, 8'h0, 8'h0, 16'h0); cyc(6);
    send(8'h02, 28'h2, 8'h0, 8'h0, 16'h0); cyc(6);
    clear_log();
    send(8'h03, 28'h3, 8'h0, 8'h0, 16'h0); cyc(6);
    chk(log_a.size() == 4 && log_a[0] == BASE_A + 48, "R3 last slot address",
        log_a.size() > 0 ? log_a[0] : 40'h0, BASE_A + 48);
    rd(3'd5, v); chk(v == 32'd0, "R3 wptr wrap", v, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    clear_log();
    send(8'h04, 28'h4, 8'h0, 8'h0, 16'h0); cyc(6);
    chk(log_a.size() == 0, "R4 dropped no write", log_a.size(), 0);
    rd(3'd5, v); chk(v == 32'h8000_0000, "R4 sticky flag, wptr held", v, 32'h80000000);
    rd(3'd7, v); chk(v == 32'd1, "R4 lost count", v, 1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0407);
    rd(3'd5, v); chk(v == 32'h0, "R5 flag cleared", v, 0);
    send(8'h05, 28'h5, 8'h0, 8'h0, 16'h0); cyc(6);
    rd(3'd5, v); chk(v == 32'h0, "R5 flag held clear during drop", v, 0);
    rd(3'd7, v); chk(v == 32'd2, "R4 lost count during clear", v, 2);
    wr(3'd0, 32'h0000_0403);
    send(8'h06, 28'h6, 8'h0, 8'h0, 16'h0); cyc(6);
    rd(3'd5, v); chk(v == 32'h8000_0000, "R5 flag sets again", v, 32'h80000000);
  endtask

  task automatic t_writeback();
    logic [31:0] v;
    wr(3'd2, 32'hABCD_0040);
    wr(3'd3, 32'h0000_0015);
    wr(3'd0, 32'h0000_040B);
    wr(3'd4, 32'd0);
    cyc(2);
    chk(irq == 1'b0, "R9 low after catch-up", irq, 0);
    clear_log();
    send(8'h07, 28'h7, 8'h0, 8'h0, 16'h0); cyc(7);
    chk(log_a.size() == 5, "R6 extra word", log_a.size(), 5);
    if (log_a.size() == 5)
      chk(log_a[4] == 40'h15_ABCD_0040 && log_d[4] == 32'h8000_0010, "R6 writeback word",
          {log_a[4], log_d[4]}, {40'h15ABCD0040, 32'h80000010});
  endtask

  task automatic t_rearm();
    wr(3'd0, 32'h0000_0413);
    cyc(2);
    chk(irq == 1'b0, "R10 no level in re-arm mode", irq, 0);
    wr(3'd4, 32'd0);
    @(negedge clk); chk(irq == 1'b1, "R10 pulse on non-empty update", irq, 1);
    @(negedge clk); chk(irq == 1'b0, "R10 pulse lasts one cycle", irq, 0);
    wr(3'd4, 32'd16);
    @(negedge clk); chk(irq == 1'b0, "R10 no pulse when emptied", irq, 0);
    @(negedge clk); chk(irq == 1'b0, "R10 still quiet", irq, 0);
  endtask

  task automatic t_doorbell();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0403);
    wr(3'd6, 32'h0001_0005);
    wr(3'd4, 32'd0);
    rd(3'd4, v); chk(v == 32'd16, "R8 register write ignored", v, 16);
    bell(10'd3, 18'd0);
    rd(3'd4, v); chk(v == 32'd16, "R8 wrong index ignored", v, 16);
    bell(10'd5, 18'd0);
    rd(3'd4, v); chk(v == 32'd0, "R8 doorbell loads rptr", v, 0);
    cyc(1);
    chk(irq == 1'b1, "R9 pending after doorbell", irq, 1);
    wr(3'd6, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0402);
    rd(3'd5, v); chk(v == 32'd0, "R7 wptr forced zero", v, 0);
    rd(3'd4, v); chk(v == 32'd0, "R7 rptr forced zero", v, 0);
    clear_log();
    send(8'h08, 28'h8, 8'h0, 8'h0, 16'h0); cyc(6);
    chk(log_a.size() == 0, "R7 no write with ring off", log_a.size(), 0);
    wr(3'd0, 32'h0000_0401);
    send(8'h09, 28'h9, 8'h0, 8'h0, 16'h0); cyc(6);
    chk(log_a.size() == 0, "R7 no write with interrupts off", log_a.size(), 0);
    rd(3'd5, v); chk(v == 32'd0, "R7 wptr unchanged", v, 0);
    chk(irq == 1'b0, "R9 low when disabled", irq, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_pack();
    t_wrap();
    t_overflow();
    t_clear();
    t_writeback();
    t_rearm();
    t_doorbell();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule